// File: doc/BRIEF.md
# Programmable Chip-Select Bus Cycle Timer

This block turns a single host request into one asynchronous read or write cycle on an external parallel bus behind one chip-select region, for example the register window of a removable flash card. The host presents an address, write data and a direction flag, and pulses a start strobe while the block signals that it is ready. The block then drives the address, an active-low chip enable, an active-low read strobe or write strobe and the outbound data. On reads it captures the returned data.

Every cycle runs as a fixed sequence of phases: address setup, enable-to-strobe delay, strobe, hold and pause. Each phase is programmed by its own field. Lengths count in units of the bus clock scaled by a global multiplier, so slow devices can be served from a fast clock with narrow fields. An optional wait mode lets a device-driven ready input stretch the strobe. After ready rises, the strobe is held for a further programmed wait count. A region enable gates all activity. A configuration bit decides whether the DMA acknowledge output follows ordinary accesses.

Top module: `cst_bus_timer`

## Requirements
- R1: The 2-bit multiplier code selects the clock scale: code 0 gives x4, code 1 gives x1, code 2 gives x2 and code 3 gives x8. A phase field value N lasts (N+1) x scale clocks.
- R2: An accepted cycle runs address setup, then enable delay, then strobe, then hold, then pause. `bus_ce_n` is low from the start of the enable delay to the end of hold. The address stays constant while `bus_ce_n` is low.
- R3: Reads pulse only `bus_oe_n` and use the read strobe and read hold fields. Writes pulse only `bus_we_n` and use the write strobe and write hold fields. The two strobes are never low together.
- R4: With wait mode on, the strobe does not end while `bus_rdy` is low once its count has run out. It then stays low for a further (WAIT+1) x scale clocks after `bus_rdy` is seen high.
- R5: Read data is captured from `bus_data_i` on the clock edge at which the read strobe deasserts. It is held on `rd_data` until the next read.
- R6: A request while the region enable is 0 produces no bus activity. It raises `done` on the next clock.
- R7: `bus_dmack_n` stays high when the DMA-acknowledge-on-access bit is 0. With the bit at 1, it is low exactly while `bus_ce_n` is low.
- R8: During writes, `bus_data_oe` is high from the start of the enable delay to the end of hold and carries the request data. It is low at every other time and during reads.
- R9: `done` is a one-clock pulse in the first idle clock after pause. `req_ready` is high only when idle, and a start pulse while busy is ignored.
- R10: After reset the block is idle with `req_ready` high, `done` low, all strobes high and the data bus released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Region enable |
| cfg_mult | input | 2 | Clock multiplier code |
| cfg_waitm | input | 1 | Wait mode enable |
| cfg_dmack_on | input | 1 | Assert DMA acknowledge on ordinary access |
| cfg_adr | input | FW | Address setup length |
| cfg_ce | input | FW | Enable-to-strobe length |
| cfg_oe | input | FW | Read strobe length |
| cfg_we | input | FW | Write strobe length |
| cfg_rdhld | input | FW | Hold after read |
| cfg_wrhld | input | FW | Hold after write |
| cfg_pause | input | FW | Pause after cycle |
| cfg_wait | input | FW | Extra strobe after ready |
| req_valid | input | 1 | Start pulse |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Write data |
| req_ready | output | 1 | Idle, may accept a start |
| done | output | 1 | One-clock completion pulse |
| rd_data | output | DW | Captured read data |
| bus_addr | output | AW | Bus address |
| bus_ce_n | output | 1 | Chip enable, active low |
| bus_oe_n | output | 1 | Read strobe, active low |
| bus_we_n | output | 1 | Write strobe, active low |
| bus_data_o | output | DW | Outbound data |
| bus_data_oe | output | 1 | Outbound data drive enable |
| bus_data_i | input | DW | Inbound data |
| bus_rdy | input | 1 | Device ready |
| bus_dmack_n | output | 1 | DMA acknowledge, active low |

## Verification
The assertions assume that all configuration inputs stay constant while a cycle is in progress. They also assume that `bus_rdy` is synchronous to `clk`, so a level seen on one edge is the level the sequencer acted on. The bench keeps within these limits. It changes the configuration only while the block is idle, with at least one idle clock before the next start. It drives every input, `bus_rdy` and `bus_data_i` included, on the falling edge.

// File: rtl/cst_pkg.sv
package cst_pkg;

  typedef enum logic [2:0] {
    PH_IDLE, PH_ADR, PH_CE, PH_STB, PH_RDYW, PH_WAITX, PH_HOLD, PH_PAUSE
  } cst_phase_e;

  localparam int SCW = 4;

  // multiplier code to clock scale
  function automatic logic [SCW-1:0] mult_scale(input logic [1:0] code);
    case (code)
      2'd0:    return SCW'(4);
      2'd1:    return SCW'(1);
      2'd2:    return SCW'(2);
      default: return SCW'(8);
    endcase
  endfunction

  function automatic logic strobe_phase(input cst_phase_e p);
    return (p == PH_STB) || (p == PH_RDYW) || (p == PH_WAITX);
  endfunction

  function automatic logic enable_phase(input cst_phase_e p);
    return strobe_phase(p) || (p == PH_CE) || (p == PH_HOLD);
  endfunction

  function automatic logic counted_phase(input cst_phase_e p);
    return (p != PH_IDLE) && (p != PH_RDYW);
  endfunction

endpackage

// File: rtl/cst_prescaler.sv
module cst_prescaler
  import cst_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] mult_code,
  output logic       tick
);
  logic [SCW-1:0] cnt_q;
  logic [SCW-1:0] last;

  assign last = mult_scale(mult_code) - SCW'(1);
  assign tick = run && (cnt_q == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (!run || tick)  cnt_q <= '0;
    else                    cnt_q <= cnt_q + SCW'(1);
  end
endmodule

// File: rtl/cst_sequencer.sv
module cst_sequencer
  import cst_pkg::*;
#(
  parameter int FW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          wr_q,
  input  logic          tick,
  input  logic          waitm,
  input  logic          rdy,
  input  logic [FW-1:0] f_adr,
  input  logic [FW-1:0] f_ce,
  input  logic [FW-1:0] f_oe,
  input  logic [FW-1:0] f_we,
  input  logic [FW-1:0] f_rdhld,
  input  logic [FW-1:0] f_wrhld,
  input  logic [FW-1:0] f_pause,
  input  logic [FW-1:0] f_wait,
  output cst_phase_e    phase,
  output logic          counting,
  output logic          strobe_end,
  output logic          cycle_end
);
  cst_phase_e    nxt;
  logic [FW-1:0] units_q;
  logic [FW-1:0] load_val;
  logic          expire;

  assign counting = counted_phase(phase);
  assign expire   = tick && (units_q == '0);

  always_comb begin
    nxt = phase;
    case (phase)
      PH_IDLE:  if (start) nxt = PH_ADR;
      PH_RDYW:  if (rdy)   nxt = PH_WAITX;
      PH_ADR:   if (expire) nxt = PH_CE;
      PH_CE:    if (expire) nxt = PH_STB;
      PH_STB:   if (expire) nxt = !waitm ? PH_HOLD : (rdy ? PH_WAITX : PH_RDYW);
      PH_WAITX: if (expire) nxt = PH_HOLD;
      PH_HOLD:  if (expire) nxt = PH_PAUSE;
      PH_PAUSE: if (expire) nxt = PH_IDLE;
      default:  nxt = PH_IDLE;
    endcase
  end

  always_comb begin
    case (nxt)
      PH_ADR:   load_val = f_adr;
      PH_CE:    load_val = f_ce;
      PH_STB:   load_val = wr_q ? f_we : f_oe;
      PH_WAITX: load_val = f_wait;
      PH_HOLD:  load_val = wr_q ? f_wrhld : f_rdhld;
      PH_PAUSE: load_val = f_pause;
      default:  load_val = '0;
    endcase
  end

  assign strobe_end = ((phase == PH_STB) || (phase == PH_WAITX)) && (nxt == PH_HOLD);
  assign cycle_end  = (phase == PH_PAUSE) && (nxt == PH_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      units_q <= '0;
    end else begin
      phase <= nxt;
      if (nxt != phase)     units_q <= load_val;
      else if (tick)        units_q <= units_q - FW'(1);
    end
  end
endmodule

// File: rtl/cst_datapath.sv
module cst_datapath #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          capture,
  input  logic [DW-1:0] din,
  output logic          wr_q,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wdata_q,
  output logic [DW-1:0] rd_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      wr_q    <= req_write;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 rd_q <= '0;
    else if (capture && !wr_q)  rd_q <= din;
  end
endmodule

// File: rtl/cst_bus_timer.sv
module cst_bus_timer
  import cst_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int FW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_en,
  input  logic [1:0]    cfg_mult,
  input  logic          cfg_waitm,
  input  logic          cfg_dmack_on,
  input  logic [FW-1:0] cfg_adr,
  input  logic [FW-1:0] cfg_ce,
  input  logic [FW-1:0] cfg_oe,
  input  logic [FW-1:0] cfg_we,
  input  logic [FW-1:0] cfg_rdhld,
  input  logic [FW-1:0] cfg_wrhld,
  input  logic [FW-1:0] cfg_pause,
  input  logic [FW-1:0] cfg_wait,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output logic          done,
  output logic [DW-1:0] rd_data,
  output logic [AW-1:0] bus_addr,
  output logic          bus_ce_n,
  output logic          bus_oe_n,
  output logic          bus_we_n,
  output logic [DW-1:0] bus_data_o,
  output logic          bus_data_oe,
  input  logic [DW-1:0] bus_data_i,
  input  logic          bus_rdy,
  output logic          bus_dmack_n
);
  cst_phase_e    phase;
  logic          accept, skip_evt, counting, tick;
  logic          strobe_end, cycle_end, wr_q, done_q;
  logic [DW-1:0] wdata_q;

  assign req_ready = (phase == PH_IDLE);
  assign accept    = req_valid && req_ready && cfg_en;
  assign skip_evt  = req_valid && req_ready && !cfg_en;

  cst_prescaler u_pre (
    .clk(clk), .rst_n(rst_n), .run(counting), .mult_code(cfg_mult), .tick(tick)
  );

  cst_sequencer #(.FW(FW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(accept), .wr_q(wr_q), .tick(tick),
    .waitm(cfg_waitm), .rdy(bus_rdy),
    .f_adr(cfg_adr), .f_ce(cfg_ce), .f_oe(cfg_oe), .f_we(cfg_we),
    .f_rdhld(cfg_rdhld), .f_wrhld(cfg_wrhld), .f_pause(cfg_pause), .f_wait(cfg_wait),
    .phase(phase), .counting(counting), .strobe_end(strobe_end), .cycle_end(cycle_end)
  );

  cst_datapath #(.AW(AW), .DW(DW)) u_dp (
    .clk(clk), .rst_n(rst_n), .accept(accept), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .capture(strobe_end),
    .din(bus_data_i), .wr_q(wr_q), .addr_q(bus_addr), .wdata_q(wdata_q), .rd_q(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= cycle_end || skip_evt;
  end
  assign done = done_q;

  always_comb begin
    bus_ce_n    = !enable_phase(phase);
    bus_oe_n    = !(strobe_phase(phase) && !wr_q);
    bus_we_n    = !(strobe_phase(phase) && wr_q);
    bus_data_oe = enable_phase(phase) && wr_q;
    bus_data_o  = wdata_q;
    bus_dmack_n = !(cfg_dmack_on && enable_phase(phase));
  end
endmodule

// File: rtl/cst_bus_timer_chk.sv
module cst_bus_timer_chk
  import cst_pkg::*;
#(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input cst_phase_e    phase,
  input logic          bus_ce_n,
  input logic          bus_oe_n,
  input logic          bus_we_n,
  input logic          bus_data_oe,
  input logic          bus_dmack_n,
  input logic          cfg_dmack_on,
  input logic          req_ready,
  input logic          done,
  input logic [AW-1:0] bus_addr,
  input logic          strobe_end,
  input logic          wr_q
);
  // R3
  no_dual_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_oe_n && !bus_we_n));
  // R2
  strobe_in_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_oe_n || !bus_we_n) |-> !bus_ce_n);
  // R2
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_ce_n && $past(!bus_ce_n)) |-> $stable(bus_addr));
  // R2
  hold_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_HOLD) |=> (phase == PH_HOLD || phase == PH_PAUSE));
  // R8
  data_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_data_oe |-> (!bus_ce_n && wr_q));
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (bus_ce_n && !bus_data_oe));
  // R7
  dmack_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_dmack_on |-> bus_dmack_n);
  // R5
  cap_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_end && !wr_q) |-> !bus_oe_n);
endmodule

bind cst_bus_timer cst_bus_timer_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .phase(phase), .bus_ce_n(bus_ce_n),
  .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n), .bus_data_oe(bus_data_oe),
  .bus_dmack_n(bus_dmack_n), .cfg_dmack_on(cfg_dmack_on), .req_ready(req_ready),
  .done(done), .bus_addr(bus_addr), .strobe_end(strobe_end), .wr_q(wr_q)
);

// File: tb/sim_cst_bus_timer.sv
module sim_cst_bus_timer;
  localparam int AW = 16, DW = 16, FW = 6;

  logic clk = 0, rst_n = 0;
  logic cfg_en = 1, cfg_waitm = 0, cfg_dmack_on = 0;
  logic [1:0] cfg_mult = 2'd1;
  logic [FW-1:0] cfg_adr = 0, cfg_ce = 0, cfg_oe = 0, cfg_we = 0;
  logic [FW-1:0] cfg_rdhld = 0, cfg_wrhld = 0, cfg_pause = 0, cfg_wait = 0;
  logic req_valid = 0, req_write = 0;
  logic [AW-1:0] req_addr = 0;
  logic [DW-1:0] req_wdata = 0, bus_data_i = 16'hDEAD;
  logic bus_rdy = 1;
  logic req_ready, done, bus_ce_n, bus_oe_n, bus_we_n, bus_data_oe, bus_dmack_n;
  logic [DW-1:0] rd_data, bus_data_o;
  logic [AW-1:0] bus_addr;

  int n_chk = 0, n_err = 0;
  bit finished = 0;
  // per-cycle observations
  int o_total, o_ce, o_stb, o_other, o_doe, o_dmack, o_addr_bad, o_data_bad, o_after;

  always #10 clk = ~clk;

  cst_bus_timer #(.AW(AW), .DW(DW), .FW(FW)) u0 (.*);

  task automatic check(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int scl(input logic [1:0] c);
    int t;
    t = (c == 2'd3) ? 8 : (c == 2'd2) ? 2 : (c == 2'd1) ? 1 : 4;
    return t;
  endfunction

  task automatic set_cfg(input logic [1:0] m, input int a, c, o, w, rh, wh, p, wt);
    cfg_mult = m; cfg_adr = FW'(a); cfg_ce = FW'(c); cfg_oe = FW'(o);
    cfg_we = FW'(w); cfg_rdhld = FW'(rh); cfg_wrhld = FW'(wh);
    cfg_pause = FW'(p); cfg_wait = FW'(wt);
  endtask

  // late_l: raise bus_rdy after this many strobe clocks (-1: leave as is)
  task automatic do_cycle(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input int late_l, input bit inject);
    bit first;
    o_total = 0; o_ce = 0; o_stb = 0; o_other = 0; o_doe = 0; o_dmack = 0;
    o_addr_bad = 0; o_data_bad = 0; o_after = 0; first = 1;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (first) begin req_valid = 0; first = 0; end
      if (inject && o_total == 2) begin
        req_valid = 1; req_addr = ~a; req_write = ~wr;
      end else if (inject && o_total == 3) req_valid = 0;
      if (done) break;
      o_total++;
      if (!bus_ce_n) begin
        o_ce++;
        if (bus_addr != a) o_addr_bad++;
      end
      if (!bus_dmack_n) o_dmack++;
      if (bus_data_oe) begin
        o_doe++;
        if (bus_data_o != d) o_data_bad++;
      end
      if (wr ? !bus_we_n : !bus_oe_n) begin
        bus_data_i = 16'h1000 + DW'(o_stb);
        o_stb++;
        if (late_l >= 0 && o_stb == late_l + 1) bus_rdy = 1;
      end else bus_data_i = 16'hDEAD;
      if (wr ? !bus_oe_n : !bus_we_n) o_other++;
    end
    req_valid = 0; bus_data_i = 16'hDEAD;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (!bus_ce_n || !req_ready || done) o_after++;
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R10 ready", req_ready, 1); check("R10 done", done, 0);
    check("R10 ce_n", bus_ce_n, 1); check("R10 oe_n", bus_oe_n, 1);
    check("R10 we_n", bus_we_n, 1); check("R10 data_oe", bus_data_oe, 0);
  endtask

  task automatic t_read(input logic [1:0] m, input int a, c, o, h, p, input logic [AW-1:0] ad);
    int s;
    s = scl(m);
    set_cfg(m, a, c, o, 9, h, 7, p, 0);
    do_cycle(0, ad, 16'h0, -1, 0);
    check("R1 read total", o_total, (a + c + o + h + p + 5) * s);
    check("R2 read ce low", o_ce, (c + o + h + 3) * s);
    check("R3 read oe low", o_stb, (o + 1) * s);
    check("R3 read we quiet", o_other, 0);
    check("R8 read no drive", o_doe, 0);
    check("R2 read addr", o_addr_bad, 0);
    check("R5 read capture", rd_data, 16'h1000 + (o + 1) * s - 1);
    check("R7 dmack idle", o_dmack, 0);
    check("R9 single done", o_after, 0);
  endtask

  task automatic t_write;
    set_cfg(2'd1, 1, 1, 5, 3, 0, 2, 1, 0);
    do_cycle(1, 16'h55AA, 16'hBEEF, -1, 0);
    check("R1 write total", o_total, 1 + 1 + 3 + 2 + 1 + 5);
    check("R3 write we low", o_stb, 4);
    check("R3 write oe quiet", o_other, 0);
    check("R2 write ce low", o_ce, 2 + 4 + 3);
    check("R8 write drive span", o_doe, 2 + 4 + 3);
    check("R8 write data", o_data_bad, 0);
    check("R5 rd_data kept on write", rd_data, 16'h1000 + 16 - 1);
  endtask

  task automatic t_wait;
    cfg_waitm = 1;
    set_cfg(2'd2, 0, 0, 1, 0, 0, 0, 0, 2);
    bus_rdy = 1;
    do_cycle(0, 16'h0101, 0, -1, 0);
    check("R4 wait rdy high strobe", o_stb, (1 + 1) * 2 + (2 + 1) * 2);
    check("R4 wait rdy high total", o_total, 2 + 2 + 4 + 6 + 2 + 2);
    set_cfg(2'd1, 0, 0, 1, 0, 0, 0, 0, 1);
    bus_rdy = 0;
    do_cycle(0, 16'h0202, 0, 6, 0);
    check("R4 wait late strobe", o_stb, 2 + 5 + 2);
    check("R5 wait late capture", rd_data, 16'h1000 + 8);
    check("R4 wait late ce", o_ce, 1 + 9 + 1);
    cfg_waitm = 0; bus_rdy = 1;
  endtask

  task automatic t_disabled;
    set_cfg(2'd1, 1, 1, 1, 1, 1, 1, 1, 0);
    cfg_en = 0;
    do_cycle(0, 16'h0777, 0, -1, 0);
    check("R6 disabled no cycle", o_total, 0);
    check("R6 disabled no ce", o_ce, 0);
    check("R6 disabled no strobe", o_stb, 0);
    cfg_en = 1;
  endtask

  task automatic t_dmack;
    set_cfg(2'd1, 1, 0, 2, 0, 1, 0, 0, 0);
    cfg_dmack_on = 1;
    do_cycle(0, 16'h0303, 0, -1, 0);
    check("R7 dmack follows ce", o_dmack, 1 + 3 + 2);
    cfg_dmack_on = 0;
  endtask

  task automatic t_busy;
    set_cfg(2'd1, 1, 0, 2, 0, 1, 0, 0, 0);
    do_cycle(0, 16'h0A0A, 0, -1, 1);
    check("R9 busy start ignored total", o_total, 2 + 1 + 3 + 2 + 1);
    check("R9 busy addr unchanged", o_addr_bad, 0);
    check("R9 no second cycle", o_after, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_read(2'd1, 1, 0, 2, 1, 0, 16'h1234);
    t_read(2'd0, 0, 1, 0, 0, 1, 16'h4321);
    t_read(2'd2, 2, 1, 3, 2, 1, 16'hA5A5);
    t_read(2'd3, 0, 0, 1, 0, 0, 16'h0F0F);
    t_write();
    t_wait();
    t_disabled();
    t_dmack();
    t_busy();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end
endmodule